// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanout Serializer

This block turns rows of a one-bit-per-pixel framebuffer into a serial video bit stream. A separate timing block issues one strobe per display line, together with the line number and a flag that says whether that line lies in the vertical active region. On a strobe that qualifies, the serializer reads one framebuffer row as 16-bit words through a synchronous read port and shifts them out least significant bit first. Each bit is held for two clocks, so one word covers 32 display pixels and the horizontal resolution is half the timing resolution.

Every row is preceded by one all-zero word, which moves the visible picture 32 pixels to the right. A row pointer moves forward by one stride only on every second active line, so each framebuffer row appears on two display lines. When the line number leaves the active region the pointer goes back to the framebuffer base. The first strobe that follows blanking only arms the block and starts no scan. The framebuffer memory and the mapping to colours are not part of this block.

Top module: `line_scan_serializer`

## Requirements
- R1: After reset `vid_out` and `fb_rd_en` are 0, the row pointer holds `BASE`, and the block counts as being in vertical blank.
- R2: A strobe starts a scan only if the strobe before it carried `line_active` = 1. After reset, or after a strobe with `line_active` = 0, the next strobe reads nothing and leaves `vid_out` at 0.
- R3: A scan sends `WORDS_PER_ROW + 1` words. The first word is all zeros and its first bit appears in the clock cycle right after the edge that samples the strobe. A scan lasts `32 * (WORDS_PER_ROW + 1)` cycles.
- R4: Each word is sent least significant bit first (bit 0 first, bit 15 last). Every bit is held on `vid_out` for exactly two clock cycles.
- R5: A scan reads addresses `scan_addr`, `scan_addr + 1`, ... up to `scan_addr + WORDS_PER_ROW - 1`, one read per word. The read for word w+1 is issued in the first cycle of word w. `fb_rd_data` is taken one cycle after `fb_rd_en`.
- R6: Word w+1 starts in the cycle right after the last cycle of bit 15 of word w, with no gap.
- R7: On a strobe with `line_active` = 1, the scan (if any) uses the current pointer. The pointer then grows by `STRIDE` if `line_num - FIRST_ACTIVE` is odd and stays the same if it is even.
- R8: On a strobe with `line_active` = 0, the pointer returns to `BASE` and stays there until the strobes that follow have active lines with odd `line_num - FIRST_ACTIVE`.
- R9: `vid_out` is 0 in every cycle in which no word is being shifted, including every cycle after the last word of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One-cycle per-line scanout strobe |
| line_num | input | LINE_W | Line number that goes with the strobe |
| line_active | input | 1 | Line lies in the vertical active region |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_rd_addr | output | ADDR_W | Framebuffer word address |
| fb_rd_data | input | 16 | Read data, valid one cycle after the request |
| vid_out | output | 1 | Serial monochrome video |

## Verification
The strobe of an odd active line does two jobs in one cycle. It starts the scan of the current row and it moves the row pointer on. A blank strobe likewise both scans the last row and rewinds the pointer. The bench runs frames in which these strobes occur and checks that the first read address of each scan is the address from before the update. A mid-frame blank line is also inserted, so that a rewind, a scan that is skipped and a restart from the base follow one another. A second collision occurs at every word boundary: the last bit period of one word and the load of the prefetched next word share one edge. The bench checks the first bit of each word in the exact cycle the requirements give.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);

    // position inside one word: which bit, and which of its two clocks
    typedef struct packed {
        logic [BIT_W-1:0] bit_idx;
        logic             second;
    } slot_t;

    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] sh;
        slot_t             slot;
    } shifter_t;

    function automatic logic slot_is_last(slot_t s);
        return (s.bit_idx == BIT_W'(WORD_W - 1)) && s.second;
    endfunction

    function automatic slot_t slot_step(slot_t s);
        slot_t n;
        if (!s.second) begin
            n.bit_idx = s.bit_idx;
            n.second  = 1'b1;
        end else begin
            n.bit_idx = s.bit_idx + 1'b1;
            n.second  = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/lscan_row_tracker.sv
module lscan_row_tracker #(
    parameter int ADDR_W       = 12,
    parameter int LINE_W       = 10,
    parameter int STRIDE       = 5,
    parameter int BASE         = 256,
    parameter int FIRST_ACTIVE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [LINE_W-1:0] line_num,
    input  logic              active,
    output logic              scan_go,
    output logic [ADDR_W-1:0] scan_addr,
    output logic [ADDR_W-1:0] row_ptr,
    output logic              in_vblank
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);
    localparam logic              FIRST_LSB = 1'(FIRST_ACTIVE % 2);

    logic odd_line;
    assign odd_line = line_num[0] ^ FIRST_LSB;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_ptr   <= BASE_A;
            in_vblank <= 1'b1;
        end else if (strobe) begin
            if (active) begin
                in_vblank <= 1'b0;
                if (odd_line)
                    row_ptr <= row_ptr + STRIDE_A;
            end else if (!in_vblank) begin
                row_ptr   <= BASE_A;
                in_vblank <= 1'b1;
            end
        end
    end

    // the scan uses the pointer value from before this strobe's update
    assign scan_go   = strobe & ~in_vblank;
    assign scan_addr = row_ptr;
endmodule

// File: rtl/lscan_word_fetch.sv
module lscan_word_fetch #(
    parameter int ADDR_W        = 12,
    parameter int WORDS_PER_ROW = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic                          word_first,
    input  logic                          word_last,
    input  logic [lscan_pkg::WORD_W-1:0]  rd_data,
    output logic                          rd_en,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic                          more,
    output logic [lscan_pkg::WORD_W-1:0]  nxt_word
);
    import lscan_pkg::*;

    localparam int CNT_W = $clog2(WORDS_PER_ROW + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS_PER_ROW);

    logic [CNT_W-1:0]  widx;     // 0 is the leading pad word
    logic [ADDR_W-1:0] cur_addr;
    logic              cap_q;

    assign more    = (widx < LAST_IDX);
    assign rd_en   = word_first & more & ~start;
    assign rd_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            widx     <= '0;
            cur_addr <= '0;
            cap_q    <= 1'b0;
            nxt_word <= '0;
        end else begin
            if (start) begin
                widx     <= '0;
                cur_addr <= start_addr;
                cap_q    <= 1'b0;
            end else begin
                cap_q <= rd_en;
                if (rd_en)
                    cur_addr <= cur_addr + 1'b1;
                if (word_last && more)
                    widx <= widx + 1'b1;
            end
            if (cap_q)
                nxt_word <= rd_data;
        end
    end
endmodule

// File: rtl/lscan_bit_shifter.sv
module lscan_bit_shifter (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          more,
    input  logic [lscan_pkg::WORD_W-1:0]  nxt_word,
    output logic                          busy,
    output logic                          half,
    output logic                          word_first,
    output logic                          word_last,
    output logic                          vid
);
    import lscan_pkg::*;

    shifter_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.busy <= 1'b1;
            st.sh   <= '0;
            st.slot <= '0;
        end else if (st.busy) begin
            if (slot_is_last(st.slot)) begin
                st.slot <= '0;
                if (more) begin
                    st.sh <= nxt_word;
                end else begin
                    st.busy <= 1'b0;
                    st.sh   <= '0;
                end
            end else begin
                st.slot <= slot_step(st.slot);
                if (st.slot.second)
                    st.sh <= st.sh >> 1;
            end
        end
    end

    assign busy       = st.busy;
    assign half       = st.slot.second;
    assign word_first = st.busy && (st.slot == '0);
    assign word_last  = st.busy && slot_is_last(st.slot);
    assign vid        = st.busy & st.sh[0];
endmodule

// File: rtl/line_scan_serializer.sv
module line_scan_serializer #(
    parameter int ADDR_W        = 12,
    parameter int LINE_W        = 10,
    parameter int WORDS_PER_ROW = 4,
    parameter int STRIDE        = 5,
    parameter int BASE          = 256,
    parameter int FIRST_ACTIVE  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_strobe,
    input  logic [LINE_W-1:0]             line_num,
    input  logic                          line_active,
    output logic                          fb_rd_en,
    output logic [ADDR_W-1:0]             fb_rd_addr,
    input  logic [lscan_pkg::WORD_W-1:0]  fb_rd_data,
    output logic                          vid_out
);
    import lscan_pkg::*;

    logic              scan_go;
    logic [ADDR_W-1:0] scan_addr;
    logic [ADDR_W-1:0] row_ptr;
    logic              in_vblank;
    logic              more;
    logic [WORD_W-1:0] nxt_word;
    logic              sh_busy;
    logic              sh_half;
    logic              word_first;
    logic              word_last;

    lscan_row_tracker #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .STRIDE(STRIDE),
        .BASE(BASE), .FIRST_ACTIVE(FIRST_ACTIVE)
    ) rows_i (
        .clk(clk), .rst(rst), .strobe(line_strobe), .line_num(line_num),
        .active(line_active), .scan_go(scan_go), .scan_addr(scan_addr),
        .row_ptr(row_ptr), .in_vblank(in_vblank)
    );

    lscan_word_fetch #(
        .ADDR_W(ADDR_W), .WORDS_PER_ROW(WORDS_PER_ROW)
    ) fetch_i (
        .clk(clk), .rst(rst), .start(scan_go), .start_addr(scan_addr),
        .word_first(word_first), .word_last(word_last), .rd_data(fb_rd_data),
        .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .more(more), .nxt_word(nxt_word)
    );

    lscan_bit_shifter shift_i (
        .clk(clk), .rst(rst), .start(scan_go), .more(more), .nxt_word(nxt_word),
        .busy(sh_busy), .half(sh_half), .word_first(word_first),
        .word_last(word_last), .vid(vid_out)
    );
endmodule

// File: rtl/line_scan_checker.sv
module line_scan_checker #(
    parameter int ADDR_W       = 12,
    parameter int LINE_W       = 10,
    parameter int BASE         = 256,
    parameter int FIRST_ACTIVE = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              line_strobe,
    input logic [LINE_W-1:0] line_num,
    input logic              line_active,
    input logic              fb_rd_en,
    input logic              vid_out,
    input logic              busy,
    input logic              half,
    input logic              in_vblank,
    input logic [ADDR_W-1:0] row_ptr
);
    localparam logic FIRST_LSB = 1'(FIRST_ACTIVE % 2);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !vid_out); // R9
    AST_FETCH_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> busy); // R5
    AST_BLANK_NO_START: assert property (@(posedge clk) disable iff (rst)
        line_strobe && in_vblank && !busy |=> !busy); // R2
    AST_START_PAD: assert property (@(posedge clk) disable iff (rst)
        line_strobe && !in_vblank |=> busy && !vid_out); // R3
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && half && $past(busy) |-> $stable(vid_out)); // R4
    AST_REWIND_BASE: assert property (@(posedge clk) disable iff (rst)
        line_strobe && !line_active |=> row_ptr == ADDR_W'(BASE)); // R8
    AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        line_strobe && line_active && (line_num[0] == FIRST_LSB) |=> $stable(row_ptr)); // R7
endmodule

bind line_scan_serializer line_scan_checker #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BASE(BASE), .FIRST_ACTIVE(FIRST_ACTIVE)
) chk_i (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .line_num(line_num),
    .line_active(line_active), .fb_rd_en(fb_rd_en), .vid_out(vid_out),
    .busy(sh_busy), .half(sh_half), .in_vblank(in_vblank), .row_ptr(row_ptr)
);

// File: tb/line_scan_serializer_tb_top.sv
module line_scan_serializer_tb_top;
    localparam int ADDR_W = 12;
    localparam int LINE_W = 10;
    localparam int WORDS  = 4;
    localparam int STRIDE = 5;
    localparam int BASE   = 256;
    localparam int FIRST  = 3;
    localparam int NACT   = 8;
    localparam int NLINES = 14;
    localparam int LINE_CYC = 200;

    typedef struct { int cyc; logic v; string tag; } vexp_t;
    typedef struct { int cyc; logic [ADDR_W-1:0] a; string tag; } aexp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_strobe = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic line_active = 1'b0;
    logic fb_rd_en;
    logic [ADDR_W-1:0] fb_rd_addr;
    logic [15:0] fb_rd_data = '0;
    logic vid_out;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    vexp_t vq[$];
    aexp_t aq[$];

    // bench model of the row pointer
    bit prev_act = 1'b0;
    int ptr = BASE;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_scan_serializer #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORDS_PER_ROW(WORDS),
        .STRIDE(STRIDE), .BASE(BASE), .FIRST_ACTIVE(FIRST)
    ) dut_i (
        .clk(clk), .rst(rst), .line_strobe(line_strobe), .line_num(line_num),
        .line_active(line_active), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .vid_out(vid_out)
    );

    function automatic logic [15:0] memfn(logic [ADDR_W-1:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'h9E37;
        return t ^ 16'hA5C3;
    endfunction

    // synchronous framebuffer model, one cycle of read latency
    always @(posedge clk) if (fb_rd_en) fb_rd_data <= memfn(fb_rd_addr);

    // driver: one line strobe, expected items pushed for any scan it starts
    task automatic do_line(input int ln, input bit act);
        int n;
        int sa;
        logic [15:0] w;
        @(negedge clk);
        line_strobe = 1'b1;
        line_num    = LINE_W'(ln);
        line_active = act;
        n = cyc;
        if (prev_act) begin
            sa = ptr;
            for (int wi = 0; wi <= WORDS; wi++) begin
                w = (wi == 0) ? 16'h0000 : memfn(ADDR_W'(sa + wi - 1));
                for (int k = 0; k < 16; k++) begin
                    for (int h = 0; h < 2; h++) begin
                        vexp_t e;
                        e.cyc = n + 1 + 32 * wi + 2 * k + h;
                        e.v   = w[k];
                        e.tag = (wi == 0) ? "R3" : ((k == 0 && h == 0) ? "R6" : "R4");
                        vq.push_back(e);
                    end
                end
            end
            for (int wi = 0; wi < WORDS; wi++) begin
                aexp_t r;
                r.cyc = n + 1 + 32 * wi;
                r.a   = ADDR_W'(sa + wi);
                r.tag = (wi != 0) ? "R5" : ((sa == BASE) ? "R8" : "R7");
                aq.push_back(r);
            end
        end
        if (act) begin
            prev_act = 1'b1;
            if (((ln - FIRST) % 2) != 0) ptr = ptr + STRIDE;
        end else if (prev_act) begin
            ptr = BASE;
            prev_act = 1'b0;
        end
        @(negedge clk);
        line_strobe = 1'b0;
        repeat (LINE_CYC - 2) @(negedge clk);
    endtask

    // monitor: compares outputs against the scoreboard every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (aq.size() > 0 && aq[0].cyc == cyc) begin
                nchk++;
                if (!fb_rd_en || fb_rd_addr !== aq[0].a) begin
                    nfail++;
                    $display("FAIL %s read: en=%0b addr=%0h expected en=1 addr=%0h",
                             aq[0].tag, fb_rd_en, fb_rd_addr, aq[0].a);
                end
                void'(aq.pop_front());
            end else if (fb_rd_en) begin
                nchk++;
                nfail++;
                $display("FAIL R2 unexpected read: en=1 addr=%0h expected en=0", fb_rd_addr);
            end
            if (vq.size() > 0 && vq[0].cyc == cyc) begin
                nchk++;
                if (vid_out !== vq[0].v) begin
                    nfail++;
                    $display("FAIL %s video at cycle %0d: got %0b expected %0b",
                             vq[0].tag, cyc, vid_out, vq[0].v);
                end
                void'(vq.pop_front());
            end else begin
                nchk++;
                if (vid_out !== 1'b0) begin
                    nfail++;
                    $display("FAIL R9 idle video at cycle %0d: got %0b expected 0", cyc, vid_out);
                end
            end
        end
    end

    task automatic run_frame(input int drop_line);
        for (int ln = 0; ln < NLINES; ln++) begin
            bit act;
            act = (ln >= FIRST) && (ln < FIRST + NACT) && (ln != drop_line);
            do_line(ln, act);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        nchk++;
        if (vid_out !== 1'b0 || fb_rd_en !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset state: vid=%0b rd_en=%0b expected 0 0", vid_out, fb_rd_en);
        end
        mon_on = 1'b1;
        run_frame(-1);              // plain frame
        run_frame(FIRST + 3);       // blank line inside the active region
        run_frame(-1);              // plain frame after the disturbed one
        repeat (300) @(negedge clk);
        nchk++;
        if (vq.size() != 0 || aq.size() != 0) begin
            nfail++;
            $display("FAIL R3 unfinished scan: %0d bits %0d reads left, expected 0 0",
                     vq.size(), aq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule